// File: doc/BRIEF.md
# Physical Timer Compare Unit

This block stores the compare value of a physical timer and decides, once per clock, whether the timer condition holds. The condition is judged against a free-running system counter that is generated elsewhere. Software loads the compare value through a simple write port and can read it back at any time. A control enable gates the condition. A separate mask input can silence the interrupt line while leaving the status bit visible.

The unit can be built for a counter narrower than 64 bits. In that case the compare field is stored at the counter width. Its upper bits read as zero, and writes to them are dropped. Both operands of the comparison are treated as zero-extended unsigned numbers.

The status bit is registered. It reflects the counter, enable and stored compare value that were present on the preceding clock edge.

Top module: `ptimer_cmp`

## Requirements
- R1: After reset the stored compare value reads as 0, `status_o` is 0 and `irq_o` is 0.
- R2: With `en_i`=1, `status_o` becomes 1 on the edge after a cycle in which `cnt_i` is greater than or equal to the stored compare value. This includes equality. Otherwise `status_o` becomes 0.
- R3: With `en_i`=0, `status_o` becomes 0 on the next edge, whatever the counter holds.
- R4: When `CNT_W` < 64, `rd_data_o[63:CNT_W]` is always 0 and write bits 63..`CNT_W` are discarded. The default build uses `CNT_W`=48.
- R5: The comparison is unsigned. A counter value with its top bit set is larger than any smaller compare value, and no wrap-around sign is applied.
- R6: A write with `wr_en_i`=1 updates the stored value at the edge that ends that cycle. The condition uses the new value from the following cycle on. A same-cycle evaluation still uses the old value.
- R7: `irq_o` equals `status_o` when `imask_i`=0 and is 0 when `imask_i`=1. The mask never alters `status_o`.
- R8: `rd_data_o` shows the zero-extended stored compare value and holds it unchanged while no write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | System counter value |
| en_i | input | 1 | Timer enable from the control register |
| imask_i | input | 1 | Interrupt mask; 1 suppresses `irq_o` |
| wr_en_i | input | 1 | Compare-value write strobe |
| wr_data_i | input | 64 | Compare-value write data |
| rd_data_o | output | 64 | Zero-extended compare value read-back |
| status_o | output | 1 | Registered timer-condition status |
| irq_o | output | 1 | Masked timer interrupt |

## Verification
Two functions can land in one cycle: a write of a new compare value, and the evaluation of the condition against the value being replaced. The bench drives a write in the same cycle that the counter crosses the old or the new threshold. The scoreboard expects the status on the next edge to follow the old value and the status one edge later to follow the new one. It also raises and drops the mask during an active condition. The expected interrupt is judged against the unchanged status.

// File: rtl/ptimer_cmp.sv
module ptimer_cmp #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             en_i,
  input  logic             imask_i,
  input  logic             wr_en_i,
  input  logic [63:0]      wr_data_i,
  output logic [63:0]      rd_data_o,
  output logic             status_o,
  output logic             irq_o
);
  localparam int RW = 64;

  logic [CNT_W-1:0] cval_q;
  logic             status_q;
  logic             unused_wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cval_q   <= '0;
      status_q <= 1'b0;
    end else begin
      status_q <= en_i && (cnt_i >= cval_q);
      if (wr_en_i) cval_q <= wr_data_i[CNT_W-1:0];
    end
  end

  assign unused_wr_hi = ^wr_data_i;
  assign rd_data_o    = RW'(cval_q);
  assign status_o     = status_q;
  assign irq_o        = status_q & ~imask_i;

  a_r2_met: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (RW'(cnt_i) >= rd_data_o)) |=> status_o);
  a_r2_not_met: assert property (@(posedge clk) disable iff (!rst_n)
    (RW'(cnt_i) < rd_data_o) |=> !status_o);
  a_r3_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !status_o);
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rd_data_o[CNT_W-1:0] == $past(wr_data_i[CNT_W-1:0]));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(rd_data_o));

  generate
    if (CNT_W < RW) begin : g_narrow
      a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[RW-1:CNT_W] == '0);
    end
  endgenerate
endmodule

// File: tb/tb_ptimer_cmp.sv
module tb_ptimer_cmp;
  localparam int CW = 48;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [CW-1:0] cnt = '0;
  logic          en = 0, imask = 0, wr_en = 0;
  logic [63:0]   wd = '0;
  logic [63:0]   rd;
  logic          st, irq;

  typedef struct {
    logic        st;
    logic [63:0] rd;
    logic        mask;
    string       tag;
  } item_t;

  item_t         sb[$];
  logic [CW-1:0] mcval = '0;
  int            n_chk = 0, n_bad = 0;
  bit            done = 0;

  always #2 clk = ~clk;

  ptimer_cmp #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .en_i(en), .imask_i(imask),
    .wr_en_i(wr_en), .wr_data_i(wd), .rd_data_o(rd), .status_o(st), .irq_o(irq));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic [CW-1:0] c, input logic w,
                      input logic [63:0] d, input logic m, input string tag);
    item_t it;
    @(negedge clk);
    en = e; cnt = c; wr_en = w; wd = d; imask = m;
    it.st = e && (c >= mcval);
    if (w) mcval = d[CW-1:0];
    it.rd = 64'(mcval);
    it.mask = m;
    it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " status"}, 64'(st), 64'(it.st));
        check({it.tag, " rd"}, rd, it.rd);
        check({it.tag, " irq"}, 64'(irq), 64'(it.st & ~it.mask));
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    #1;
    check("R1 status", 64'(st), 0);
    check("R1 rd", rd, 0);
    check("R1 irq", 64'(irq), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: zero compare, counter 0, enabled -> equal -> met
    step(1, 0, 0, 0, 0, "R1 R2 zero");
    // R8 / R4: write full ones; upper bits dropped
    step(0, 5, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R4 R3 write ones");
    step(1, {CW{1'b1}}, 0, 0, 0, "R4 R5 max equal");
    step(1, {CW{1'b1}} - 1, 0, 0, 0, "R2 below max");
    // R2 threshold with equality
    step(1, 0, 1, 64'h0000_0000_0000_1000, 0, "R8 write 1000");
    step(1, 48'hFFF, 0, 0, 0, "R2 below");
    step(1, 48'h1000, 0, 0, 0, "R2 equal");
    step(1, 48'h1001, 0, 0, 0, "R2 above");
    step(0, 48'h9000, 0, 0, 0, "R3 disabled");
    // R5 unsigned: counter top bit set vs small compare
    step(1, 48'h8000_0000_0000, 0, 0, 0, "R5 top bit");
    step(1, 0, 1, 64'h0000_8000_0000_0000, 0, "R5 write top");
    step(1, 48'h7FFF_FFFF_FFFF, 0, 0, 0, "R5 no wrap");
    // R6 same-cycle write: old value decides this edge
    step(1, 48'h8000_0000_0000, 1, 64'h0000_9000_0000_0000, 0, "R6 old value");
    step(1, 48'h8000_0000_0000, 0, 0, 0, "R6 new value");
    step(1, 48'h10, 1, 64'h0000_0000_0000_0010, 0, "R6 write while below");
    step(1, 48'h10, 0, 0, 0, "R6 next cycle met");
    // R7 mask
    step(1, 48'h20, 0, 0, 1, "R7 masked");
    step(1, 48'h20, 0, 0, 0, "R7 unmasked");
    step(1, 48'h20, 0, 0, 1, "R7 remasked");
    // R4 upper write bits ignored
    step(1, 48'h5, 1, 64'hABCD_0000_0000_0006, 0, "R4 upper drop");
    step(1, 48'h5, 0, 0, 0, "R4 R8 readback");
    step(1, 48'h6, 0, 0, 0, "R8 hold");
    @(negedge clk);
    wr_en = 0;
    wait (sb.size() == 0);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule